// File: doc/BRIEF.md
# Signed Less-Or-Equal-Zero Branch Resolver with Optional Delay Slot

This block settles one conditional branch for a small in-order CPU front end: "branch when the operand is less than or equal to zero". It receives a decoded branch request with two mode bits, the operand to test, and a PC-relative offset. One mode bit selects the compare width: the full 64-bit signed operand, or only its low 32 bits taken as a signed value. The other mode bit selects whether the branch has a delay slot.

Each accepted request updates a registered next-PC. A taken branch also raises a one-cycle redirect pulse. When a taken branch has no delay slot, a flush pulse squashes the wrong-path fetch. A stall counter models the extra latency of a taken branch and holds `ready` low while it runs. Two parameters set that latency: an area-optimised mode and a memory-management level.

The block also tracks when a delay-slot instruction is pending. While it is pending, the block holds back interrupt and external break requests. It also flags an immediate-prefix, branch or break instruction that lands in the slot.

Top module: `lez_branch_unit`

## Requirements
- R1: The branch is taken when the tested value, read as signed, is less than or equal to zero. With `longCmp`=1 the tested value is all 64 bits of `cmpOpnd`. With `longCmp`=0 it is `cmpOpnd[31:0]` only, and bits 63:32 have no effect.
- R2: One clock edge after a request is accepted, `nextPc` holds `pcIn + offsetOpnd` for a taken branch and `pcIn + 4` for a not-taken branch. `nextPc` changes at no other time.
- R3: `redirect` pulses high for exactly one cycle after an accepted taken branch, and never after a not-taken branch.
- R4: `flush` pulses together with `redirect` only when the taken branch has `delaySlot`=0.
- R5: With default parameters, `ready` goes low after an accepted branch for a set number of cycles: 0 cycles when not taken, 1 cycle when taken with `delaySlot`=1, and 2 cycles when taken with `delaySlot`=0.
- R6: With `AREA_OPT`=1, a taken branch holds `ready` low for 5 cycles with a delay slot and 6 cycles without one. Each count grows by 2 when `MMU_LEVEL` > 1.
- R7: A branch request that arrives while `ready` is low is ignored. It changes neither `nextPc` nor `redirect`.
- R8: `inSlot` rises after any accepted branch with `delaySlot`=1, whether taken or not. It falls after the next cycle with `instrValid`=1.
- R9: `irqTake` and `brkTake` follow `irqReq` and `brkReq`, except that both are held low while `inSlot` is high and in the cycle a delay-slot branch is accepted.
- R10: `slotIllegal` is high when `instrValid` is high, `inSlot` is high and `instrClass` is 1 (immediate prefix), 2 (branch) or 3 (break). It is low for class 0 (any other instruction) and for any instruction outside a slot.
- R11: During reset, `ready` is high and `redirect`, `flush`, `inSlot` and `nextPc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brValid | input | 1 | Decoded branch request |
| longCmp | input | 1 | 1: 64-bit compare, 0: 32-bit compare |
| delaySlot | input | 1 | 1: branch has a delay slot |
| pcIn | input | 32 | Address of the branch |
| cmpOpnd | input | 64 | Operand tested against zero |
| offsetOpnd | input | 32 | Offset added to the PC when taken |
| instrValid | input | 1 | An instruction following the branch issues |
| instrClass | input | 2 | 0 other, 1 immediate prefix, 2 branch, 3 break |
| irqReq | input | 1 | Interrupt request |
| brkReq | input | 1 | External break request |
| nextPc | output | 32 | Resolved next PC |
| redirect | output | 1 | One-cycle taken-branch strobe |
| flush | output | 1 | Squash the wrong-path fetch |
| ready | output | 1 | Block can accept a branch |
| inSlot | output | 1 | Delay-slot instruction pending |
| slotIllegal | output | 1 | Forbidden instruction in the delay slot |
| irqTake | output | 1 | Interrupt released to the core |
| brkTake | output | 1 | Break released to the core |

## Verification
The compare is tried at zero, -1, +1 and the most negative value at both widths. In 32-bit mode the upper word is always set so that it would reverse the result if it leaked in, so these cases tell a correct width select from a truncation or sign-extension error. The table mixes positive and negative offsets with both slot settings, so redirect, flush and stall length can be checked for all four combinations of taken and slot. Directed tests then check the ignored request during a stall, interrupt and break deferral across a slot, each forbidden slot class, and the stall counts of a second instance built in area mode with a memory-management level above 1.

// File: rtl/lez_pkg.sv
package lez_pkg;
  typedef struct packed {
    logic loadPc;
    logic useTarget;
  } lez_strobe_t;

  typedef enum logic [1:0] {
    CLS_OTHER  = 2'd0,
    CLS_IMM    = 2'd1,
    CLS_BRANCH = 2'd2,
    CLS_BREAK  = 2'd3
  } lez_class_e;
endpackage

// File: rtl/lez_datapath.sv
module lez_datapath import lez_pkg::*; #(
  parameter int PC_W    = 32,
  parameter int OPND_W  = 64,
  parameter int SHORT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [OPND_W-1:0] cmpOpnd,
  input  logic [PC_W-1:0]   offsetOpnd,
  input  logic              longCmp,
  input  lez_strobe_t       strobe,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [SHORT_W-1:0] shortVal;
  logic shortLez, longLez;

  assign shortVal = cmpOpnd[SHORT_W-1:0];
  // Signed <= 0 is the sign bit set, or the value equal to zero.
  assign shortLez = shortVal[SHORT_W-1] | (shortVal == '0);
  assign longLez  = cmpOpnd[OPND_W-1]   | (cmpOpnd == '0);
  assign taken    = longCmp ? longLez : shortLez;

  always_ff @(posedge clk) begin
    if (!rstN)
      nextPc <= '0;
    else if (strobe.loadPc)
      nextPc <= strobe.useTarget ? pcIn + offsetOpnd : pcIn + STEP;
  end

  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadPc |=> $stable(nextPc));
endmodule

// File: rtl/lez_ctrl.sv
module lez_ctrl import lez_pkg::*; #(
  parameter int AREA_OPT  = 0,
  parameter int MMU_LEVEL = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        brValid,
  input  logic        delaySlot,
  input  logic        taken,
  input  logic        instrValid,
  input  logic [1:0]  instrClass,
  input  logic        irqReq,
  input  logic        brkReq,
  output lez_strobe_t strobe,
  output logic        redirect,
  output logic        flush,
  output logic        ready,
  output logic        inSlot,
  output logic        slotIllegal,
  output logic        irqTake,
  output logic        brkTake
);
  localparam int MMU_EXTRA = (AREA_OPT != 0 && MMU_LEVEL > 1) ? 2 : 0;
  localparam int STALL_DS  = (AREA_OPT != 0) ? 5 + MMU_EXTRA : 1;
  localparam int STALL_ND  = STALL_DS + 1;
  localparam int CNT_W     = $clog2(STALL_ND + 1);

  logic [CNT_W-1:0] stallCnt;
  logic accept, hold;
  lez_class_e cls;

  assign ready  = (stallCnt == '0);
  assign accept = brValid & ready;
  assign cls    = lez_class_e'(instrClass);
  assign strobe = '{loadPc: accept, useTarget: taken};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt <= '0;
      redirect <= 1'b0;
      flush    <= 1'b0;
      inSlot   <= 1'b0;
    end else begin
      redirect <= accept & taken;
      flush    <= accept & taken & ~delaySlot;
      if (accept && taken)
        stallCnt <= delaySlot ? CNT_W'(STALL_DS) : CNT_W'(STALL_ND);
      else if (!ready)
        stallCnt <= stallCnt - 1'b1;
      if (accept && delaySlot)
        inSlot <= 1'b1;
      else if (instrValid)
        inSlot <= 1'b0;
    end
  end

  assign hold        = inSlot | (accept & delaySlot);
  assign irqTake     = irqReq & ~hold;
  assign brkTake     = brkReq & ~hold;
  assign slotIllegal = instrValid & inSlot & (cls != CLS_OTHER);

  // R3
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !redirect);
  // R4
  flush_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> redirect);
  // R5
  stall_after_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && taken) |=> !ready);
  // R8
  slot_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inSlot && instrValid && !accept) |=> !inSlot);
  // R9
  irq_defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    inSlot |-> (!irqTake && !brkTake));
  // R10
  illegal_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotIllegal |-> inSlot);
endmodule

// File: rtl/lez_branch_unit.sv
module lez_branch_unit import lez_pkg::*; #(
  parameter int AREA_OPT  = 0,
  parameter int MMU_LEVEL = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        brValid,
  input  logic        longCmp,
  input  logic        delaySlot,
  input  logic [31:0] pcIn,
  input  logic [63:0] cmpOpnd,
  input  logic [31:0] offsetOpnd,
  input  logic        instrValid,
  input  logic [1:0]  instrClass,
  input  logic        irqReq,
  input  logic        brkReq,
  output logic [31:0] nextPc,
  output logic        redirect,
  output logic        flush,
  output logic        ready,
  output logic        inSlot,
  output logic        slotIllegal,
  output logic        irqTake,
  output logic        brkTake
);
  lez_strobe_t strobe;
  logic taken;

  lez_ctrl #(.AREA_OPT(AREA_OPT), .MMU_LEVEL(MMU_LEVEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .brValid(brValid), .delaySlot(delaySlot),
    .taken(taken), .instrValid(instrValid), .instrClass(instrClass),
    .irqReq(irqReq), .brkReq(brkReq), .strobe(strobe),
    .redirect(redirect), .flush(flush), .ready(ready), .inSlot(inSlot),
    .slotIllegal(slotIllegal), .irqTake(irqTake), .brkTake(brkTake)
  );

  lez_datapath #(.PC_W(32), .OPND_W(64), .SHORT_W(32)) u_dp (
    .clk(clk), .rstN(rstN), .pcIn(pcIn), .cmpOpnd(cmpOpnd),
    .offsetOpnd(offsetOpnd), .longCmp(longCmp), .strobe(strobe),
    .taken(taken), .nextPc(nextPc)
  );
endmodule

// File: tb/lez_branch_unit_tb.sv
module lez_branch_unit_tb;
  typedef struct packed {
    logic        l;
    logic        d;
    logic [63:0] cmp;
    logic [31:0] off;
    logic        tk;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 64'hFFFF_FFFF_0000_0000, 32'h0000_0100, 1'b1}, // 32b zero, upper negative
    '{1'b0, 1'b1, 64'h0000_0000_FFFF_FFFF, 32'hFFFF_FFF0, 1'b1}, // 32b -1, 64b positive
    '{1'b0, 1'b0, 64'hFFFF_FFFF_0000_0001, 32'h0000_0040, 1'b0}, // 32b +1, 64b negative
    '{1'b0, 1'b1, 64'h0000_0001_8000_0000, 32'h0000_0020, 1'b1}, // 32b most negative
    '{1'b0, 1'b0, 64'hFFFF_FFFF_7FFF_FFFF, 32'h0000_0080, 1'b0}, // 32b max positive
    '{1'b1, 1'b0, 64'h0000_0000_0000_0000, 32'h0000_0200, 1'b1}, // 64b zero
    '{1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FF00, 1'b1}, // 64b -1
    '{1'b1, 1'b0, 64'h0000_0000_0000_0001, 32'h0000_0010, 1'b0}, // 64b +1
    '{1'b1, 1'b1, 64'h8000_0000_0000_0000, 32'h0000_0400, 1'b1}, // 64b most negative
    '{1'b1, 1'b0, 64'h0000_0000_FFFF_FFFF, 32'h0000_0008, 1'b0}, // 64b positive, low word -1
    '{1'b1, 1'b1, 64'h0000_0001_0000_0000, 32'h0000_0008, 1'b0}, // 64b positive, low word 0
    '{1'b0, 1'b1, 64'h8000_0000_0000_0002, 32'h0000_0030, 1'b0}  // 32b +2, upper negative
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic brValid = 0, longCmp = 0, delaySlot = 0, instrValid = 0, irqReq = 0, brkReq = 0;
  logic [31:0] pcIn = '0, offsetOpnd = '0;
  logic [63:0] cmpOpnd = '0;
  logic [1:0]  instrClass = '0;
  logic [31:0] nextPc, nextPcA;
  logic redirect, flush, ready, inSlot, slotIllegal, irqTake, brkTake;
  logic redirectA, flushA, readyA, inSlotA, slotIllegalA, irqTakeA, brkTakeA;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lez_branch_unit u_dut (
    .clk(clk), .rstN(rstN), .brValid(brValid), .longCmp(longCmp), .delaySlot(delaySlot),
    .pcIn(pcIn), .cmpOpnd(cmpOpnd), .offsetOpnd(offsetOpnd), .instrValid(instrValid),
    .instrClass(instrClass), .irqReq(irqReq), .brkReq(brkReq), .nextPc(nextPc),
    .redirect(redirect), .flush(flush), .ready(ready), .inSlot(inSlot),
    .slotIllegal(slotIllegal), .irqTake(irqTake), .brkTake(brkTake));

  lez_branch_unit #(.AREA_OPT(1), .MMU_LEVEL(2)) u_dutArea (
    .clk(clk), .rstN(rstN), .brValid(brValid), .longCmp(longCmp), .delaySlot(delaySlot),
    .pcIn(pcIn), .cmpOpnd(cmpOpnd), .offsetOpnd(offsetOpnd), .instrValid(instrValid),
    .instrClass(instrClass), .irqReq(irqReq), .brkReq(brkReq), .nextPc(nextPcA),
    .redirect(redirectA), .flush(flushA), .ready(readyA), .inSlot(inSlotA),
    .slotIllegal(slotIllegalA), .irqTake(irqTakeA), .brkTake(brkTakeA));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitReady();
    while (!(ready && readyA)) @(negedge clk);
  endtask

  task automatic driveBr(input logic l, input logic d, input logic [63:0] c,
                         input logic [31:0] pc, input logic [31:0] off);
    brValid = 1; longCmp = l; delaySlot = d; cmpOpnd = c; pcIn = pc; offsetOpnd = off;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lowCnt;
    logic [31:0] expPc;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 ready", ready, 1);
    check("R11 redirect", redirect, 0);
    check("R11 flush", flush, 0);
    check("R11 inSlot", inSlot, 0);
    check("R11 nextPc", nextPc, 0);
    rstN = 1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R8 R10
    for (int i = 0; i < NV; i++) begin
      waitReady();
      driveBr(VEC[i].l, VEC[i].d, VEC[i].cmp, 32'h1000 + 32'(i) * 32'h10, VEC[i].off);
      expPc = VEC[i].tk ? pcIn + VEC[i].off : pcIn + 32'd4;
      @(negedge clk);
      brValid = 0;
      check($sformatf("R1 taken vec%0d", i), redirect, VEC[i].tk);
      check($sformatf("R2 nextPc vec%0d", i), nextPc, expPc);
      check($sformatf("R4 flush vec%0d", i), flush, VEC[i].tk & ~VEC[i].d);
      check($sformatf("R8 inSlot vec%0d", i), inSlot, VEC[i].d);
      lowCnt = 0;
      while (!ready && lowCnt < 20) begin
        lowCnt++;
        if (lowCnt == 1) begin
          @(negedge clk);
          check($sformatf("R3 pulse vec%0d", i), redirect, 0);
        end else @(negedge clk);
      end
      check($sformatf("R5 stall vec%0d", i), lowCnt, VEC[i].tk ? (VEC[i].d ? 1 : 2) : 0);
      if (VEC[i].d) begin
        instrValid = 1; instrClass = 2'd0;
        #1 check($sformatf("R10 class0 vec%0d", i), slotIllegal, 0);
        @(negedge clk);
        instrValid = 0;
        check($sformatf("R8 cleared vec%0d", i), inSlot, 0);
      end
    end

    // R7: request during stall is ignored
    waitReady();
    driveBr(1'b1, 1'b0, 64'd0, 32'h2000, 32'h40);
    @(negedge clk);
    driveBr(1'b1, 1'b0, 64'd0, 32'h3000, 32'h80);
    check("R7 not ready", ready, 0);
    @(negedge clk);
    brValid = 0;
    check("R7 no redirect", redirect, 0);
    check("R7 nextPc held", nextPc, 32'h2040);

    // R9 R10: deferral and illegal classes in the slot
    for (int k = 1; k < 4; k++) begin
      waitReady();
      irqReq = 1; brkReq = 1;
      driveBr(1'b0, 1'b1, 64'd1, 32'h4000, 32'h10);
      #1 check("R9 hold at accept", {irqTake, brkTake}, 0);
      @(negedge clk);
      brValid = 0;
      check("R9 irq held in slot", irqTake, 0);
      check("R9 brk held in slot", brkTake, 0);
      instrValid = 1; instrClass = 2'(k);
      #1 check($sformatf("R10 class%0d illegal", k), slotIllegal, 1);
      @(negedge clk);
      instrValid = 0;
      check("R9 irq released", irqTake, 1);
      check("R9 brk released", brkTake, 1);
      irqReq = 0; brkReq = 0;
    end
    instrValid = 1; instrClass = 2'd2;
    #1 check("R10 outside slot", slotIllegal, 0);
    @(negedge clk);
    instrValid = 0;

    // R6: area mode with memory-management level 2
    for (int d = 1; d >= 0; d--) begin
      waitReady();
      driveBr(1'b0, 1'(d), 64'd0, 32'h5000, 32'h20);
      @(negedge clk);
      brValid = 0;
      lowCnt = 0;
      while (!readyA && lowCnt < 30) begin lowCnt++; @(negedge clk); end
      check($sformatf("R6 area stall d=%0d", d), lowCnt, d ? 7 : 8);
      instrValid = 1; instrClass = 2'd0;
      @(negedge clk);
      instrValid = 0;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule